// File: doc/BRIEF.md
# Reorder Buffer with Precise Exceptions

This block is a circular reorder buffer. The front end writes instructions into it in program order. Execution units then send completion reports in any order. Each report names the slot it finishes and carries a result. It can also carry an exception marker, a fault-or-trap class and a cause code.

A report only stores data in its slot. Architectural state changes only at the oldest slot, and at most once per cycle:
- A finished entry with no exception goes out on the commit port as a register write.
- A finished entry with an exception is not written. Instead the block asserts a one-cycle exception-taken pulse and empties the buffer in that cycle, which drops the entry and every younger one. In the same cycle it outputs the return PC, the cause code and the handler address for fetch.

Because exceptions are only acted on at the oldest slot, the reported exception is always the oldest one in program order. This holds even when several reports arrive together.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `disp_ready_o` is 1, `disp_idx_o` is 0, and `commit_valid_o` and `exc_taken_o` are 0.
- R2: Each accepted dispatch (`disp_valid_i` and `disp_ready_o` high at a clock edge) takes the slot shown on `disp_idx_o`. Successive dispatches receive consecutive indices modulo DEPTH.
- R3: Once DEPTH entries are held, `disp_ready_o` is 0. A dispatch offered while it is 0 is dropped and occupies no slot.
- R4: Results are held until every older entry has left the buffer. Commits follow dispatch order, one per cycle. `commit_valid_o` rises in the cycle after the oldest entry's report edge, showing that entry's rd, data and PC. The entry leaves at the next edge.
- R5: A completion report naming a slot that holds no live entry is ignored. A later dispatch into that slot is not treated as finished.
- R6: When the oldest entry is finished and excepting, `exc_taken_o` is high for exactly one cycle with `commit_valid_o` low. That entry and all younger ones are dropped without commit. The buffer is empty afterwards: the next dispatch reuses the excepting entry's slot, and reports for dropped slots are ignored.
- R7: `cmp_trap_i` = 0 marks a fault and `exc_epc_o` equals the entry's PC. `cmp_trap_i` = 1 marks a trap and `exc_epc_o` equals PC+4. `exc_cause_o` repeats the reported cause code.
- R8: While `exc_taken_o` is high, `exc_redirect_o` equals the parameter VECTOR (default 0x100).
- R9: When several entries carry exceptions, including reports on different ports in the same cycle, only the oldest is reported. Younger ones never raise `exc_taken_o`. Port number does not affect this.
- R10: During the exception-taken cycle `disp_ready_o` is 0, and a dispatch offered then is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| disp_valid_i | input | 1 | Dispatch request |
| disp_pc_i | input | PC_W | PC of dispatched instruction |
| disp_rd_i | input | REG_W | Destination register |
| disp_ready_o | output | 1 | Slot available for dispatch |
| disp_idx_o | output | IDX_W | Slot index granted to this dispatch |
| cmp_valid_i | input | NCMP | Completion report valid, one per port |
| cmp_idx_i | input | NCMP x IDX_W | Slot index of each report |
| cmp_data_i | input | NCMP x DATA_W | Result of each report |
| cmp_exc_i | input | NCMP | Report carries an exception |
| cmp_trap_i | input | NCMP | Exception class: 0 fault, 1 trap |
| cmp_cause_i | input | NCMP x CAUSE_W | Exception cause code |
| commit_valid_o | output | 1 | Oldest entry is writing the register file this cycle |
| commit_rd_o | output | REG_W | Committed destination register |
| commit_data_o | output | DATA_W | Committed result |
| commit_pc_o | output | PC_W | PC of committed instruction |
| exc_taken_o | output | 1 | One-cycle exception and flush pulse |
| exc_epc_o | output | PC_W | Return PC for the handler |
| exc_cause_o | output | CAUSE_W | Cause of the taken exception |
| exc_redirect_o | output | PC_W | Fetch redirect address (handler vector) |

## Verification
A dispatch index is visible before the dispatching edge. A completion report is stored at one edge, so commit or exception outputs for the oldest entry are due in the cycle after that edge. Retirement or squash then happens at the next edge, and the effect shows one cycle later. The bench changes inputs on the falling edge and samples every output just before the following rising edge, which places each check exactly in the cycle where its result is due. Dropped dispatches and ignored reports are detected through later slot indices and the absence of commits.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic {
    EXC_FAULT = 1'b0,
    EXC_TRAP  = 1'b1
  } exc_kind_e;

  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             retire_i,
  input  logic             flush_i,
  output logic [IDX_W-1:0] head_idx_o,
  output logic [IDX_W-1:0] tail_idx_o,
  output logic             full_o,
  output logic             empty_o
);
  // extra MSB is the wrap bit; DEPTH must be a power of two
  logic [IDX_W:0] head_q, tail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush_i) begin
      tail_q <= head_q;
    end else begin
      if (alloc_i)  tail_q <= tail_q + 1'b1;
      if (retire_i) head_q <= head_q + 1'b1;
    end
  end

  assign head_idx_o = head_q[IDX_W-1:0];
  assign tail_idx_o = tail_q[IDX_W-1:0];
  assign empty_o    = (head_q == tail_q);
  assign full_o     = (head_q[IDX_W] != tail_q[IDX_W]) &&
                      (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]);

  // R3
  no_alloc_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !full_o);
  // R4
  retire_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |-> !empty_o);
  // R6
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter  int unsigned DEPTH   = 8,
  parameter  int unsigned NCMP    = 2,
  parameter  int unsigned PC_W    = 32,
  parameter  int unsigned DATA_W  = 32,
  parameter  int unsigned REG_W   = 5,
  parameter  int unsigned CAUSE_W = 5,
  localparam int unsigned IDX_W   = $clog2(DEPTH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           alloc_i,
  input  logic [IDX_W-1:0]               alloc_idx_i,
  input  logic [PC_W-1:0]                alloc_pc_i,
  input  logic [REG_W-1:0]               alloc_rd_i,
  input  logic [NCMP-1:0]                cmp_valid_i,
  input  logic [NCMP-1:0][IDX_W-1:0]     cmp_idx_i,
  input  logic [NCMP-1:0][DATA_W-1:0]    cmp_data_i,
  input  logic [NCMP-1:0]                cmp_exc_i,
  input  logic [NCMP-1:0]                cmp_kind_i,
  input  logic [NCMP-1:0][CAUSE_W-1:0]   cmp_cause_i,
  input  logic                           retire_i,
  input  logic                           flush_i,
  input  logic [IDX_W-1:0]               head_idx_i,
  output logic                           head_valid_o,
  output logic                           head_done_o,
  output logic                           head_exc_o,
  output exc_kind_e                      head_kind_o,
  output logic [CAUSE_W-1:0]             head_cause_o,
  output logic [PC_W-1:0]                head_pc_o,
  output logic [REG_W-1:0]               head_rd_o,
  output logic [DATA_W-1:0]              head_data_o
);
  typedef struct packed {
    logic               valid;
    logic               done;
    logic               exc;
    exc_kind_e          kind;
    logic [CAUSE_W-1:0] cause;
    logic [PC_W-1:0]    pc;
    logic [REG_W-1:0]   rd;
    logic [DATA_W-1:0]  data;
  } ent_t;

  ent_t ent_all [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    ent_t ent_q, ent_d;

    always_comb begin
      ent_d = ent_q;
      if (flush_i) begin
        ent_d.valid = 1'b0;
      end else begin
        if (retire_i && head_idx_i == MY_IDX) ent_d.valid = 1'b0;
        if (alloc_i && alloc_idx_i == MY_IDX) begin
          ent_d       = '0;
          ent_d.valid = 1'b1;
          ent_d.pc    = alloc_pc_i;
          ent_d.rd    = alloc_rd_i;
        end
        // reports only land on live, unfinished entries; lowest port wins a tie
        if (ent_q.valid && !ent_q.done) begin
          for (int p = int'(NCMP) - 1; p >= 0; p--) begin
            if (cmp_valid_i[p] && cmp_idx_i[p] == MY_IDX) begin
              ent_d.done  = 1'b1;
              ent_d.data  = cmp_data_i[p];
              ent_d.exc   = cmp_exc_i[p];
              ent_d.kind  = exc_kind_e'(cmp_kind_i[p]);
              ent_d.cause = cmp_cause_i[p];
            end
          end
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q <= '0;
      else         ent_q <= ent_d;
    end

    assign ent_all[i] = ent_q;
  end

  ent_t head;
  assign head         = ent_all[head_idx_i];
  assign head_valid_o = head.valid;
  assign head_done_o  = head.done;
  assign head_exc_o   = head.exc;
  assign head_kind_o  = head.kind;
  assign head_cause_o = head.cause;
  assign head_pc_o    = head.pc;
  assign head_rd_o    = head.rd;
  assign head_data_o  = head.data;

  // R4
  retire_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |-> (head_valid_o && head_done_o && !head_exc_o));
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int unsigned     PC_W    = 32,
  parameter int unsigned     CAUSE_W = 5,
  parameter logic [PC_W-1:0] VECTOR  = 'h100
) (
  input  logic               valid_i,
  input  logic               done_i,
  input  logic               exc_i,
  input  exc_kind_e          kind_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [PC_W-1:0]    pc_i,
  output logic               commit_o,
  output logic               flush_o,
  output logic [PC_W-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [PC_W-1:0]    redirect_o
);
  logic ready;
  assign ready    = valid_i && done_i;
  assign commit_o = ready && !exc_i;
  assign flush_o  = ready && exc_i;

  // fault replays the instruction, trap resumes after it
  always_comb begin
    epc_o      = '0;
    cause_o    = '0;
    redirect_o = '0;
    if (flush_o) begin
      epc_o      = pc_i + ((kind_i == EXC_TRAP) ? PC_W'(INSN_BYTES) : '0);
      cause_o    = cause_i;
      redirect_o = VECTOR;
    end
  end
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter  int unsigned     DEPTH   = 8,
  parameter  int unsigned     NCMP    = 2,
  parameter  int unsigned     PC_W    = 32,
  parameter  int unsigned     DATA_W  = 32,
  parameter  int unsigned     REG_W   = 5,
  parameter  int unsigned     CAUSE_W = 5,
  parameter  logic [PC_W-1:0] VECTOR  = 'h100,
  localparam int unsigned     IDX_W   = $clog2(DEPTH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         disp_valid_i,
  input  logic [PC_W-1:0]              disp_pc_i,
  input  logic [REG_W-1:0]             disp_rd_i,
  output logic                         disp_ready_o,
  output logic [IDX_W-1:0]             disp_idx_o,
  input  logic [NCMP-1:0]              cmp_valid_i,
  input  logic [NCMP-1:0][IDX_W-1:0]   cmp_idx_i,
  input  logic [NCMP-1:0][DATA_W-1:0]  cmp_data_i,
  input  logic [NCMP-1:0]              cmp_exc_i,
  input  logic [NCMP-1:0]              cmp_trap_i,
  input  logic [NCMP-1:0][CAUSE_W-1:0] cmp_cause_i,
  output logic                         commit_valid_o,
  output logic [REG_W-1:0]             commit_rd_o,
  output logic [DATA_W-1:0]            commit_data_o,
  output logic [PC_W-1:0]              commit_pc_o,
  output logic                         exc_taken_o,
  output logic [PC_W-1:0]              exc_epc_o,
  output logic [CAUSE_W-1:0]           exc_cause_o,
  output logic [PC_W-1:0]              exc_redirect_o
);
  logic             alloc, full, empty;
  logic [IDX_W-1:0] head_idx, tail_idx;
  logic             h_valid, h_done, h_exc;
  exc_kind_e        h_kind;
  logic [CAUSE_W-1:0] h_cause;
  logic [PC_W-1:0]  h_pc;

  assign disp_ready_o = !full && !exc_taken_o;
  assign alloc        = disp_valid_i && disp_ready_o;
  assign disp_idx_o   = tail_idx;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alloc_i    (alloc),
    .retire_i   (commit_valid_o),
    .flush_i    (exc_taken_o),
    .head_idx_o (head_idx),
    .tail_idx_o (tail_idx),
    .full_o     (full),
    .empty_o    (empty)
  );

  rob_store #(
    .DEPTH(DEPTH), .NCMP(NCMP), .PC_W(PC_W), .DATA_W(DATA_W),
    .REG_W(REG_W), .CAUSE_W(CAUSE_W)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (alloc),
    .alloc_idx_i  (tail_idx),
    .alloc_pc_i   (disp_pc_i),
    .alloc_rd_i   (disp_rd_i),
    .cmp_valid_i  (cmp_valid_i),
    .cmp_idx_i    (cmp_idx_i),
    .cmp_data_i   (cmp_data_i),
    .cmp_exc_i    (cmp_exc_i),
    .cmp_kind_i   (cmp_trap_i),
    .cmp_cause_i  (cmp_cause_i),
    .retire_i     (commit_valid_o),
    .flush_i      (exc_taken_o),
    .head_idx_i   (head_idx),
    .head_valid_o (h_valid),
    .head_done_o  (h_done),
    .head_exc_o   (h_exc),
    .head_kind_o  (h_kind),
    .head_cause_o (h_cause),
    .head_pc_o    (h_pc),
    .head_rd_o    (commit_rd_o),
    .head_data_o  (commit_data_o)
  );

  rob_retire #(.PC_W(PC_W), .CAUSE_W(CAUSE_W), .VECTOR(VECTOR)) u_retire (
    .valid_i    (h_valid),
    .done_i     (h_done),
    .exc_i      (h_exc),
    .kind_i     (h_kind),
    .cause_i    (h_cause),
    .pc_i       (h_pc),
    .commit_o   (commit_valid_o),
    .flush_o    (exc_taken_o),
    .epc_o      (exc_epc_o),
    .cause_o    (exc_cause_o),
    .redirect_o (exc_redirect_o)
  );

  assign commit_pc_o = h_pc;

  // R6
  exc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_taken_o |=> !exc_taken_o);
  // R6
  squash_no_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_taken_o |=> !commit_valid_o);
  // R1
  empty_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> (!commit_valid_o && !exc_taken_o));
endmodule

// File: tb/rob_core_tb_top.sv
`timescale 1ns/1ps
module rob_core_tb_top;
  localparam int DEPTH = 8;
  localparam int NCMP  = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic              disp_valid_i = 1'b0;
  logic [31:0]       disp_pc_i = '0;
  logic [4:0]        disp_rd_i = '0;
  logic              disp_ready_o;
  logic [2:0]        disp_idx_o;
  logic [NCMP-1:0]   cmp_valid_i = '0;
  logic [NCMP-1:0][2:0]  cmp_idx_i = '0;
  logic [NCMP-1:0][31:0] cmp_data_i = '0;
  logic [NCMP-1:0]   cmp_exc_i = '0;
  logic [NCMP-1:0]   cmp_trap_i = '0;
  logic [NCMP-1:0][4:0]  cmp_cause_i = '0;
  logic              commit_valid_o;
  logic [4:0]        commit_rd_o;
  logic [31:0]       commit_data_o, commit_pc_o;
  logic              exc_taken_o;
  logic [31:0]       exc_epc_o;
  logic [4:0]        exc_cause_o;
  logic [31:0]       exc_redirect_o;

  rob_core dut_i (.*);

  int tests = 0;
  int fails = 0;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] data;
    logic        exc;
    logic        trap;
    logic [4:0]  cause;
    logic [31:0] epc;
  } row_t;

  localparam row_t TBL [6] = '{
    '{32'h0000_1000, 32'h0000_AAAA, 1'b0, 1'b0, 5'd0,  32'h0},
    '{32'h0000_2000, 32'h0000_1234, 1'b1, 1'b0, 5'd3,  32'h0000_2000},
    '{32'h0000_3000, 32'h0,         1'b1, 1'b1, 5'd8,  32'h0000_3004},
    '{32'h0000_4FFC, 32'h0000_0055, 1'b0, 1'b0, 5'd0,  32'h0},
    '{32'h0000_5000, 32'h0,         1'b1, 1'b1, 5'd11, 32'h0000_5004},
    '{32'h0000_6000, 32'h0,         1'b1, 1'b0, 5'd13, 32'h0000_6000}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic dispatch(input logic [31:0] pc, input logic [4:0] rd,
                          output logic [2:0] idx);
    disp_valid_i = 1'b1;
    disp_pc_i    = pc;
    disp_rd_i    = rd;
    idx          = disp_idx_o;
    step();
    disp_valid_i = 1'b0;
  endtask

  task automatic set_cmp(input int p, input logic [2:0] idx, input logic [31:0] data,
                         input logic exc, input logic trap, input logic [4:0] cause);
    cmp_valid_i[p] = 1'b1;
    cmp_idx_i[p]   = idx;
    cmp_data_i[p]  = data;
    cmp_exc_i[p]   = exc;
    cmp_trap_i[p]  = trap;
    cmp_cause_i[p] = cause;
  endtask

  task automatic complete(input logic [2:0] idx, input logic [31:0] data,
                          input logic exc, input logic trap, input logic [4:0] cause);
    set_cmp(0, idx, data, exc, trap, cause);
    step();
    cmp_valid_i = '0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [2:0] ix, ia, ib, ic, id, t0, islots [DEPTH];
    @(negedge clk_i);
    @(negedge clk_i);
    // R1 reset state
    chk("R1", "disp_ready", 32'(disp_ready_o), 32'd1);
    chk("R1", "disp_idx", 32'(disp_idx_o), 32'd0);
    chk("R1", "commit_valid", 32'(commit_valid_o), 32'd0);
    chk("R1", "exc_taken", 32'(exc_taken_o), 32'd0);
    rst_ni = 1'b1;
    step();

    // table: single entry, commit or exception (R4 R7 R8)
    for (int k = 0; k < 6; k++) begin
      dispatch(TBL[k].pc, 5'(k + 1), ix);
      complete(ix, TBL[k].data, TBL[k].exc, TBL[k].trap, TBL[k].cause);
      if (TBL[k].exc) begin
        chk("R6", "exc_taken", 32'(exc_taken_o), 32'd1);
        chk("R6", "no commit on exc", 32'(commit_valid_o), 32'd0);
        chk("R7", "epc", exc_epc_o, TBL[k].epc);
        chk("R7", "cause", 32'(exc_cause_o), 32'(TBL[k].cause));
        chk("R8", "redirect", exc_redirect_o, 32'h100);
      end else begin
        chk("R4", "commit_valid", 32'(commit_valid_o), 32'd1);
        chk("R4", "commit_pc", commit_pc_o, TBL[k].pc);
        chk("R4", "commit_data", commit_data_o, TBL[k].data);
        chk("R4", "commit_rd", 32'(commit_rd_o), 32'(k + 1));
      end
      step();
      chk("R6", "pulse ended", 32'(exc_taken_o), 32'd0);
      chk("R4", "single commit", 32'(commit_valid_o), 32'd0);
    end

    // R2 R4 out-of-order completion, in-order commit
    dispatch(32'hA000, 5'd1, ia);
    dispatch(32'hA004, 5'd2, ib);
    dispatch(32'hA008, 5'd3, ic);
    chk("R2", "idx b", 32'(ib), 32'(3'(ia + 3'd1)));
    chk("R2", "idx c", 32'(ic), 32'(3'(ia + 3'd2)));
    complete(ic, 32'hC, 1'b0, 1'b0, 5'd0);
    complete(ib, 32'hB, 1'b0, 1'b0, 5'd0);
    chk("R4", "younger held", 32'(commit_valid_o), 32'd0);
    complete(ia, 32'hA, 1'b0, 1'b0, 5'd0);
    chk("R4", "commit a pc", commit_pc_o, 32'hA000);
    step();
    chk("R4", "commit b pc", commit_pc_o, 32'hA004);
    chk("R4", "commit b data", commit_data_o, 32'hB);
    step();
    chk("R4", "commit c pc", commit_pc_o, 32'hA008);
    step();
    chk("R4", "drained", 32'(commit_valid_o), 32'd0);

    // R3 full stall, dropped dispatch
    for (int k = 0; k < DEPTH; k++) dispatch(32'h8000 + 32'(k * 4), 5'(k), islots[k]);
    chk("R3", "ready when full", 32'(disp_ready_o), 32'd0);
    dispatch(32'hDEAD, 5'd31, ix);
    for (int k = DEPTH - 1; k >= 0; k--) complete(islots[k], 32'(k), 1'b0, 1'b0, 5'd0);
    for (int k = 0; k < DEPTH; k++) begin
      chk("R3", "commit pc order", commit_pc_o, 32'h8000 + 32'(k * 4));
      chk("R3", "commit valid", 32'(commit_valid_o), 32'd1);
      step();
    end
    chk("R3", "no extra entry", 32'(commit_valid_o), 32'd0);
    chk("R3", "ready after drain", 32'(disp_ready_o), 32'd1);

    // R5 report to empty slot ignored
    t0 = disp_idx_o;
    complete(t0, 32'h5555, 1'b0, 1'b0, 5'd0);
    chk("R5", "no commit from stale", 32'(commit_valid_o), 32'd0);
    dispatch(32'h9000, 5'd4, ix);
    chk("R5", "slot reused", 32'(ix), 32'(t0));
    chk("R5", "new entry not done", 32'(commit_valid_o), 32'd0);
    complete(ix, 32'h9, 1'b0, 1'b0, 5'd0);
    chk("R5", "commit after report", commit_pc_o, 32'h9000);
    step();

    // R9 oldest wins, R10 dispatch refused in flush cycle, R6 squash
    dispatch(32'h7000, 5'd1, ia);
    dispatch(32'h7100, 5'd2, ib);
    dispatch(32'h7200, 5'd3, ic);
    set_cmp(0, ic, 32'h0, 1'b1, 1'b0, 5'd5);
    set_cmp(1, ib, 32'h0, 1'b1, 1'b1, 5'd9);
    step();
    cmp_valid_i = '0;
    chk("R9", "no exc before oldest done", 32'(exc_taken_o), 32'd0);
    complete(ia, 32'h1, 1'b0, 1'b0, 5'd0);
    chk("R9", "older commits first", commit_pc_o, 32'h7000);
    step();
    chk("R9", "exc taken for b", 32'(exc_taken_o), 32'd1);
    chk("R9", "epc of oldest", exc_epc_o, 32'h7104);
    chk("R9", "cause of oldest", 32'(exc_cause_o), 32'd9);
    chk("R10", "ready in flush", 32'(disp_ready_o), 32'd0);
    dispatch(32'hBAD0, 5'd7, ix);
    chk("R9", "younger never reported", 32'(exc_taken_o), 32'd0);
    chk("R6", "c squashed", 32'(commit_valid_o), 32'd0);
    chk("R6", "ready after flush", 32'(disp_ready_o), 32'd1);
    complete(ic, 32'hCC, 1'b0, 1'b0, 5'd0);
    chk("R6", "report to squashed ignored", 32'(commit_valid_o), 32'd0);
    dispatch(32'hE000, 5'd6, id);
    chk("R10", "flush dispatch dropped", 32'(id), 32'(ib));
    complete(id, 32'hEE, 1'b0, 1'b0, 5'd0);
    chk("R6", "new entry commits", commit_pc_o, 32'hE000);
    chk("R6", "new entry data", commit_data_o, 32'hEE);
    step();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule